// File: doc/BRIEF.md
# Cache Event Performance Counter Block

This block watches a cache's single-cycle event strobes and counts them in a bank of software-programmed 64-bit counters. It also keeps a free-running 64-bit clock counter. Software reaches the block over a plain 64-bit register bus with a byte address, a write strobe, a read strobe and write data. Read data comes back one clock after the read strobe.

Each event counter has a 32-bit selector that names the event it counts. Any counter, including the clock counter, can be preloaded at any time. A common use is to preload a counter to half of full scale, so that software has a wide margin before a wrap.

When a counter wraps past all ones, its bit in a sticky overflow register is set. An interrupt line rises when an overflow bit and the matching enable bit are both set. Overflow bits are cleared by writing ones to them.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register map, using aligned byte offsets:
  - 0x040 enable register: only bit 0 is stored.
  - 0x048 overflow register.
  - 0x050 interrupt-enable register: only bits 0–15 and bit 63 are stored.
  - 0x058 clock counter.
  - 0x060+8·n selector of counter n: only bits 31:0 are stored.
  - 0x160+8·n event counter n, for n = 0..15.
  - Bits that are not stored read as zero.
- R3: `evt_pulse` bit k carries event k, with these selector codes:
  - 0 read request, 0x04000701
  - 1 write request, 0x03000001
  - 2 release request, 0x0003e001
  - 3 read hit, 0x00901202
  - 4 read miss, 0x04008002
  - 5 write hit, 0x006c0002
  - 6 write miss, 0x03000002
  - 7 writeback, 0x00000403
  
  While enabled, a counter adds one on every clock in which its selected event bit is high. A selector that matches no listed code makes its counter count nothing. Counters that share a code count the same pulses.
- R4: While the enable bit (0x040 bit 0) is clear, no counter changes except by a bus write.
- R5: While the enable bit is set, the clock counter adds one on every clock, with no selector involved.
- R6: A value written to any counter is kept, and counting continues from it.
- R7: When a counter wraps from all ones to zero, its overflow bit is set. Event counter n uses bit n and the clock counter uses bit 63.
- R8: Writing 1 to an overflow bit clears it. Bits written with 0 are kept.
- R9: If an overflow bit is set and cleared by a write in the same clock, it ends up set.
- R10: `irq` is high one clock after any bit is set in both the overflow and interrupt-enable registers, and low one clock after no such bit remains.
- R11: Reads from unmapped or unaligned offsets return zero, and writes to them change nothing.
- R12: A bus write to a counter in the same clock as an increment loads the written value. The increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered, valid one clock after `bus_rd` |
| evt_pulse | input | 8 | Event strobes from the cache, one bit per event kind |
| irq | output | 1 | Overflow interrupt, registered |

## Verification
Two functions can land on the same clock edge, and the bench provokes each case on purpose.

- **Overflow set against overflow clear.** The bench preloads the clock counter with all ones and sets the enable bit. It then issues a write-one-to-clear of bit 63 on exactly the edge where the counter wraps. It judges the outcome by reading the overflow register: bit 63 must still be set, and a later plain clear must remove it.
- **Counter load against increment.** The bench holds an event strobe high and writes the counter on an edge where it would also count. The read-back value must show that the increment in the load cycle was dropped, while counting on later edges went on.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_EVT = 8;

  // event k is carried on evt_pulse[k]
  localparam logic [31:0] EVT_CODES [NUM_EVT] = '{
    32'h0400_0701,  // read request
    32'h0300_0001,  // write request
    32'h0003_e001,  // release request
    32'h0090_1202,  // read hit
    32'h0400_8002,  // read miss
    32'h006c_0002,  // write hit
    32'h0300_0002,  // write miss
    32'h0000_0403   // writeback
  };

  // 64-bit word indices (byte offset / 8)
  localparam int WI_CTRL = 'h08;
  localparam int WI_OVF  = 'h09;
  localparam int WI_IE   = 'h0A;
  localparam int WI_CYC  = 'h0B;
  localparam int WI_SEL  = 'h0C;
  localparam int WI_CNT  = 'h2C;

  localparam int CYC_BIT = 63;
endpackage

// File: rtl/pmu_evt_decode.sv
module pmu_evt_decode
  import pmu_pkg::*;
(
  input  logic [31:0]        code_i,
  output logic [NUM_EVT-1:0] match_o
);
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_cmp
    assign match_o[k] = (code_i == EVT_CODES[k]);
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = inc_i && !ld_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));

  a_r12_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 16,
  parameter int CNT_W   = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [63:0]        bus_wdata,
  output logic [63:0]        bus_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               irq
);
  localparam int WI_W = ADDR_W - 3;
  localparam logic [63:0] BIT_MASK =
    {1'b1, {(63-NUM_CNT){1'b0}}, {NUM_CNT{1'b1}}};

  logic [WI_W-1:0] widx;
  logic            aligned;
  assign widx    = bus_addr[ADDR_W-1:3];
  assign aligned = (bus_addr[2:0] == 3'b000);

  logic               ctrl_en;
  logic [63:0]        ie_q, ovf_q, ovf_set, ovf_clr;
  logic [31:0]        sel_q   [NUM_CNT];
  logic [NUM_EVT-1:0] match   [NUM_CNT];
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] sel_wr, cnt_wr, cnt_inc, evt_wrap;
  logic               ctrl_wr, ovf_wr, ie_wr, cyc_wr, cyc_wrap;
  logic [CNT_W-1:0]   cyc_val;
  logic [63:0]        rd_mux;
  logic               rd_hit;

  // write decode
  always_comb begin
    ctrl_wr = bus_wr && aligned && (widx == WI_W'(WI_CTRL));
    ovf_wr  = bus_wr && aligned && (widx == WI_W'(WI_OVF));
    ie_wr   = bus_wr && aligned && (widx == WI_W'(WI_IE));
    cyc_wr  = bus_wr && aligned && (widx == WI_W'(WI_CYC));
    for (int n = 0; n < NUM_CNT; n++) begin
      sel_wr[n] = bus_wr && aligned && (widx == WI_W'(WI_SEL + n));
      cnt_wr[n] = bus_wr && aligned && (widx == WI_W'(WI_CNT + n));
    end
  end

  // event counters
  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    pmu_evt_decode u_dec (
      .code_i  (sel_q[n]),
      .match_o (match[n])
    );
    assign cnt_inc[n] = ctrl_en && |(match[n] & evt_pulse);
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .ld_i     (cnt_wr[n]),
      .ld_val_i (bus_wdata[CNT_W-1:0]),
      .inc_i    (cnt_inc[n]),
      .cnt_o    (cnt_val[n]),
      .wrap_o   (evt_wrap[n])
    );
  end

  // clock counter
  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (cyc_wr),
    .ld_val_i (bus_wdata[CNT_W-1:0]),
    .inc_i    (ctrl_en),
    .cnt_o    (cyc_val),
    .wrap_o   (cyc_wrap)
  );

  always_comb begin
    ovf_set = '0;
    ovf_set[NUM_CNT-1:0] = evt_wrap;
    ovf_set[CYC_BIT]     = cyc_wrap;
    ovf_clr = ovf_wr ? (bus_wdata & BIT_MASK) : '0;
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    rd_hit = 1'b0;
    if (aligned) begin
      if (widx == WI_W'(WI_CTRL)) begin rd_mux[0] = ctrl_en; rd_hit = 1'b1; end
      if (widx == WI_W'(WI_OVF))  begin rd_mux = ovf_q;      rd_hit = 1'b1; end
      if (widx == WI_W'(WI_IE))   begin rd_mux = ie_q;       rd_hit = 1'b1; end
      if (widx == WI_W'(WI_CYC))  begin rd_mux[CNT_W-1:0] = cyc_val; rd_hit = 1'b1; end
      for (int n = 0; n < NUM_CNT; n++) begin
        if (widx == WI_W'(WI_SEL + n)) begin
          rd_mux[31:0] = sel_q[n];
          rd_hit = 1'b1;
        end
        if (widx == WI_W'(WI_CNT + n)) begin
          rd_mux[CNT_W-1:0] = cnt_val[n];
          rd_hit = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ie_q      <= '0;
      ovf_q     <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
      for (int n = 0; n < NUM_CNT; n++) sel_q[n] <= '0;
    end else begin
      if (ctrl_wr) ctrl_en <= bus_wdata[0];
      if (ie_wr)   ie_q    <= bus_wdata & BIT_MASK;
      ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
      irq   <= |(ovf_q & ie_q);
      if (bus_rd) bus_rdata <= rd_mux;
      for (int n = 0; n < NUM_CNT; n++)
        if (sel_wr[n]) sel_q[n] <= bus_wdata[31:0];
    end
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ovf_set != '0) |=> ((ovf_q & $past(ovf_set)) == $past(ovf_set)));

  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (ovf_wr && ovf_set == '0) |=> ((ovf_q & $past(bus_wdata & BIT_MASK)) == '0));

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (ie_q == '0) |=> !irq);

  a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !rd_hit) |=> (bus_rdata == '0));

  a_r4_cycle_holds: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !cyc_wr) |=> $stable(cyc_val));
endmodule

// File: tb/test_perf_mon_unit.sv
module test_perf_mon_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic [7:0]  evt_pulse;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [31:0] C_RDREQ = 32'h0400_0701;
  localparam logic [31:0] C_RDHIT = 32'h0090_1202;
  localparam logic [31:0] C_WRHIT = 32'h006c_0002;
  localparam logic [31:0] C_WRMIS = 32'h0300_0002;
  localparam logic [31:0] C_WBACK = 32'h0000_0403;
  localparam logic [11:0] A_CTRL = 12'h040, A_OVF = 12'h048,
                          A_IE = 12'h050, A_CYC = 12'h058;

  always #4 clk = ~clk;

  perf_mon_unit i_perf_mon_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  function automatic logic [11:0] sel_a(int n); return 12'(12'h060 + 8*n); endfunction
  function automatic logic [11:0] cnt_a(int n); return 12'(12'h160 + 8*n); endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [11:0] a, logic [63:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(string req, logic [11:0] a, logic [63:0] exp);
    logic [63:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    rd_check("R1 ctrl", A_CTRL, 0);
    rd_check("R1 ovf", A_OVF, 0);
    rd_check("R1 ie", A_IE, 0);
    rd_check("R1 cyc", A_CYC, 0);
    rd_check("R1 sel0", sel_a(0), 0);
    rd_check("R1 cnt15", cnt_a(15), 0);
    check("R1 irq", 64'(irq), 0);
  endtask

  task automatic t_regs;
    wr(sel_a(7), 64'hAAAA_BBBB_CCCC_DDDD);
    rd_check("R2 sel width", sel_a(7), 64'h0000_0000_CCCC_DDDD);
    wr(A_IE, '1);
    rd_check("R2 ie mask", A_IE, 64'h8000_0000_0000_FFFF);
    wr(A_IE, 0);
    wr(A_CTRL, 64'hFF);
    rd_check("R2 ctrl bit0", A_CTRL, 1);
    wr(A_CTRL, 0);
  endtask

  task automatic t_count;
    wr(sel_a(0), 64'(C_RDREQ));
    wr(sel_a(1), 64'(C_RDREQ));
    wr(sel_a(2), 64'h1234_5678);
    wr(sel_a(3), 64'(C_WRHIT));
    wr(A_CTRL, 1);
    evt_pulse = 8'b0010_0001; repeat (3) @(negedge clk);
    evt_pulse = 8'b0000_0001; repeat (2) @(negedge clk);
    evt_pulse = 8'hFF;        repeat (2) @(negedge clk);
    evt_pulse = 8'h00;
    wr(A_CTRL, 0);
    rd_check("R3 cnt0 read request", cnt_a(0), 7);
    rd_check("R3 cnt1 same code", cnt_a(1), 7);
    rd_check("R3 cnt2 unknown code", cnt_a(2), 0);
    rd_check("R3 cnt3 write hit", cnt_a(3), 5);
    evt_pulse = 8'hFF; repeat (4) @(negedge clk); evt_pulse = 8'h00;
    rd_check("R4 cnt0 disabled", cnt_a(0), 7);
    rd_check("R4 cnt3 disabled", cnt_a(3), 5);
  endtask

  task automatic t_cycle;
    wr(A_CYC, 100);
    wr(A_CTRL, 1);
    repeat (6) @(negedge clk);
    wr(A_CTRL, 0);
    rd_check("R5 cycle count", A_CYC, 107);
    repeat (3) @(negedge clk);
    rd_check("R4 cycle held", A_CYC, 107);
  endtask

  task automatic t_preload;
    wr(sel_a(4), 64'(C_WRMIS));
    wr(cnt_a(4), 64'h7FFF_FFFF_FFFF_FFFF);
    rd_check("R6 preload kept", cnt_a(4), 64'h7FFF_FFFF_FFFF_FFFF);
    wr(A_CTRL, 1);
    evt_pulse = 8'b0100_0000; repeat (3) @(negedge clk); evt_pulse = 0;
    wr(A_CTRL, 0);
    rd_check("R6 count from preload", cnt_a(4), 64'h8000_0000_0000_0002);
  endtask

  task automatic t_wrap_irq;
    wr(sel_a(5), 64'(C_WBACK));
    wr(cnt_a(5), 64'hFFFF_FFFF_FFFF_FFFE);
    wr(A_CTRL, 1);
    evt_pulse = 8'b1000_0000; repeat (3) @(negedge clk); evt_pulse = 0;
    wr(A_CTRL, 0);
    rd_check("R7 wrapped value", cnt_a(5), 1);
    rd_check("R7 overflow bit5", A_OVF, 64'h20);
    check("R10 irq masked", 64'(irq), 0);
    wr(A_IE, 64'h20);
    @(negedge clk);
    check("R10 irq raised", 64'(irq), 1);
    wr(A_OVF, 64'h10);
    rd_check("R8 zero bits kept", A_OVF, 64'h20);
    wr(A_OVF, 64'h20);
    @(negedge clk);
    check("R10 irq dropped", 64'(irq), 0);
    rd_check("R8 cleared", A_OVF, 0);
    wr(A_IE, 0);
  endtask

  task automatic t_set_wins;
    wr(A_CYC, '1);
    wr(A_CTRL, 1);
    wr(A_OVF, 64'h8000_0000_0000_0000);  // same edge as the wrap
    wr(A_CTRL, 0);
    rd_check("R9 set wins", A_OVF, 64'h8000_0000_0000_0000);
    rd_check("R7 cycle wrapped", A_CYC, 1);
    wr(A_OVF, 64'h8000_0000_0000_0000);
    rd_check("R8 cycle bit cleared", A_OVF, 0);
  endtask

  task automatic t_load_wins;
    wr(sel_a(6), 64'(C_RDHIT));
    evt_pulse = 8'b0000_1000;
    wr(A_CTRL, 1);
    wr(cnt_a(6), 1000);
    wr(A_CTRL, 0);
    evt_pulse = 0;
    rd_check("R12 load over increment", cnt_a(6), 1001);
  endtask

  task automatic t_unmapped;
    rd_check("R11 read 0x000", 12'h000, 0);
    rd_check("R11 read 0x1E0", 12'h1E0, 0);
    rd_check("R11 read unaligned", 12'h044, 0);
    wr(12'h1E0, '1);
    wr(12'h100, '1);
    wr(12'h041, '1);
    rd_check("R11 ctrl untouched", A_CTRL, 0);
    rd_check("R11 ie untouched", A_IE, 0);
    rd_check("R11 cnt15 untouched", cnt_a(15), 0);
    rd_check("R11 0x100 still zero", 12'h100, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; evt_pulse = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_regs;
    t_count;
    t_cycle;
    t_preload;
    t_wrap_irq;
    t_set_wins;
    t_load_wins;
    t_unmapped;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule